// File: doc/BRIEF.md
# Shifted-Operand Unit with Carry-Out

This block produces the second operand of a RISC data-processing datapath. It takes the instruction word, the source register value, the current program counter, the incoming carry flag and a register-held shift amount. It returns the shifted operand together with the shifter carry-out. The shift is computed combinationally and captured in an output register one cycle after a valid input.

A second mode serves load/store address offsets. In that mode only immediate-amount shifts are used and the carry register is left untouched.

The shift amount normally comes from the instruction. An amount of zero does not always mean "no shift": for the right shifts and the rotate it selects a shift by the full word width, or a one-bit rotate that passes through the carry. Register-held amounts follow their own rules at and above the word width.

Top module: `opshift_unit`

## Requirements
- R1: The shift kind comes from instruction bits [6:5], coded as 0 = logical left, 1 = logical right, 2 = arithmetic right and 3 = rotate right. Bit 4 set selects the register-held amount and bit 4 clear selects the immediate amount in bits [11:7]. With `in_valid` high at a clock edge, `out_valid` is high after that edge and `operand`/`carry_out` show the result of that input.
- R2: An immediate logical left shift by n (1..31) gives the input shifted left by n, with carry-out equal to input bit 32−n. By 0, the input and the incoming carry pass through unchanged.
- R3: An immediate logical right shift by n (1..31) gives carry-out equal to input bit n−1. By 0 it acts as a 32-bit shift: the result is zero and carry-out is input bit 31.
- R4: An immediate arithmetic right shift by n (1..31) sign-fills, with carry-out equal to input bit n−1. By 0, every result bit and the carry-out equal input bit 31.
- R5: An immediate rotate right by n (1..31) gives carry-out equal to input bit n−1. By 0 it performs a one-bit rotate through carry: the incoming carry enters bit 31, the rest is the input shifted right by one, and carry-out is input bit 0.
- R6: When instruction bits [3:0] equal 15, the shifted value is `pc`+8 instead of `rm_val`.
- R7: A register-held amount uses only bits [7:0] of `amt_reg`. An amount of 0 passes the input and the incoming carry through unchanged for every shift kind. Amounts 1..31 behave as the immediate forms with the same n.
- R8: A register-held logical left or right shift by exactly 32 gives zero, with carry-out equal to input bit 0 (left) or bit 31 (right). Amounts of 33 or more give zero with carry-out 0.
- R9: A register-held arithmetic right shift by 32 or more sign-fills, with carry-out equal to input bit 31. A register-held rotate uses the amount modulo 32. A nonzero multiple of 32 returns the input unchanged with carry-out equal to input bit 31.
- R10: With `ls_mode` high, bit 4 is ignored and the immediate form of R2..R5 is used. `carry_out` keeps its previous value.
- R11: After reset, `out_valid`, `operand` and `carry_out` are 0. In a cycle without `in_valid`, `out_valid` is 0 and `operand` and `carry_out` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input set is valid this cycle |
| ls_mode | input | 1 | Load/store offset mode, immediate only, no carry update |
| instr | input | 32 | Instruction word |
| rm_val | input | 32 | Source register value |
| pc | input | 32 | Current program counter |
| carry_in | input | 1 | Incoming carry flag |
| amt_reg | input | 32 | Register holding the shift amount (low byte used) |
| out_valid | output | 1 | Registered result valid |
| operand | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench targets the zero-amount immediate encodings. A design that treated them literally would pass the input through for the right shifts and miss the carry entering bit 31 on the rotate. It also targets register amounts of exactly 32, 33 and nonzero multiples of 32. A design that wrapped or masked the amount there would return a shifted value or a wrong carry instead of zero or a sign fill. It drives source index 15, where a missing PC+8 substitution shows as the register value. It also uses offset mode with bit 4 set, where a design that honoured bit 4 or updated the carry would diverge from the model.

// File: rtl/opshift_pkg.sv
package opshift_pkg;
    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    localparam int KIND_LO  = 5;
    localparam int USE_REG  = 4;
    localparam int IMM_LO   = 7;
    localparam int IDX_W    = 4;
endpackage

// File: rtl/opshift_src.sv
module opshift_src #(
    parameter int W      = 32,
    parameter int IDX_W  = 4,
    parameter int PC_OFS = 8
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     rm_val,
    input  logic [W-1:0]     pc,
    output logic [W-1:0]     src
);
    localparam logic [IDX_W-1:0] PC_IDX = {IDX_W{1'b1}};

    always_comb begin
        if (idx == PC_IDX) src = pc + W'(PC_OFS);
        else               src = rm_val;
    end
endmodule

// File: rtl/opshift_imm.sv
module opshift_imm
    import opshift_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  shift_kind_e    kind,
    input  logic [SW-1:0]  amt,
    input  logic [W-1:0]   x,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);
    logic [W:0]          wide_l;
    logic [W:0]          wide_r;
    logic signed [W:0]   wide_s;
    logic [2*W-1:0]      dbl;

    always_comb begin
        wide_l = {1'b0, x} << amt;
        wide_r = {x, 1'b0} >> amt;
        wide_s = $signed({x, 1'b0}) >>> amt;
        dbl    = {x, x} >> amt;
        res    = x;
        cout   = cin;
        unique case (kind)
            SH_LSL: begin
                if (amt != '0) begin
                    res  = wide_l[W-1:0];
                    cout = wide_l[W];
                end
            end
            SH_LSR: begin
                if (amt == '0) begin
                    res  = '0;
                    cout = x[W-1];
                end else begin
                    res  = wide_r[W:1];
                    cout = wide_r[0];
                end
            end
            SH_ASR: begin
                if (amt == '0) begin
                    res  = {W{x[W-1]}};
                    cout = x[W-1];
                end else begin
                    res  = wide_s[W:1];
                    cout = wide_s[0];
                end
            end
            SH_ROR: begin
                if (amt == '0) begin
                    res  = {cin, x[W-1:1]};
                    cout = x[0];
                end else begin
                    res  = dbl[W-1:0];
                    cout = dbl[W-1];
                end
            end
        endcase
    end
endmodule

// File: rtl/opshift_reg.sv
module opshift_reg
    import opshift_pkg::*;
#(
    parameter int W     = 32,
    parameter int SW    = $clog2(W),
    parameter int AMT_W = 8
) (
    input  shift_kind_e      kind,
    input  logic [AMT_W-1:0] amt,
    input  logic [W-1:0]     x,
    input  logic             cin,
    output logic [W-1:0]     res,
    output logic             cout
);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(W);

    logic [SW-1:0]       rot;
    logic [W:0]          wide_l;
    logic [W:0]          wide_r;
    logic signed [W:0]   wide_s;
    logic [2*W-1:0]      dbl;

    always_comb begin
        rot    = amt[SW-1:0];
        wide_l = {1'b0, x} << amt;
        wide_r = {x, 1'b0} >> amt;
        wide_s = $signed({x, 1'b0}) >>> amt;
        dbl    = {x, x} >> rot;
        res    = x;
        cout   = cin;
        if (amt != '0) begin
            unique case (kind)
                SH_LSL: begin
                    res  = (amt <= FULL) ? wide_l[W-1:0] : '0;
                    cout = (amt <= FULL) ? wide_l[W] : 1'b0;
                end
                SH_LSR: begin
                    res  = (amt <= FULL) ? wide_r[W:1] : '0;
                    cout = (amt <= FULL) ? wide_r[0] : 1'b0;
                end
                SH_ASR: begin
                    res  = (amt >= FULL) ? {W{x[W-1]}} : wide_s[W:1];
                    cout = (amt >= FULL) ? x[W-1] : wide_s[0];
                end
                SH_ROR: begin
                    res  = dbl[W-1:0];
                    cout = dbl[W-1];
                end
            endcase
        end
    end
endmodule

// File: rtl/opshift_unit.sv
module opshift_unit
    import opshift_pkg::*;
#(
    parameter int W      = 32,
    parameter int AMT_W  = 8,
    parameter int PC_OFS = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         ls_mode,
    input  logic [W-1:0] instr,
    input  logic [W-1:0] rm_val,
    input  logic [W-1:0] pc,
    input  logic         carry_in,
    input  logic [W-1:0] amt_reg,
    output logic         out_valid,
    output logic [W-1:0] operand,
    output logic         carry_out
);
    localparam int SW = $clog2(W);

    shift_kind_e   kind;
    logic          use_reg;
    logic [SW-1:0] imm_amt;
    logic [W-1:0]  src;
    logic [W-1:0]  imm_res, reg_res, nxt_res;
    logic          imm_c, reg_c, nxt_c;

    assign kind    = shift_kind_e'(instr[KIND_LO+1:KIND_LO]);
    assign use_reg = instr[USE_REG] & ~ls_mode;
    assign imm_amt = instr[IMM_LO+SW-1:IMM_LO];

    opshift_src #(.W(W), .IDX_W(IDX_W), .PC_OFS(PC_OFS)) u_src (
        .idx(instr[IDX_W-1:0]), .rm_val(rm_val), .pc(pc), .src(src)
    );

    opshift_imm #(.W(W), .SW(SW)) u_imm (
        .kind(kind), .amt(imm_amt), .x(src), .cin(carry_in),
        .res(imm_res), .cout(imm_c)
    );

    opshift_reg #(.W(W), .SW(SW), .AMT_W(AMT_W)) u_reg (
        .kind(kind), .amt(amt_reg[AMT_W-1:0]), .x(src), .cin(carry_in),
        .res(reg_res), .cout(reg_c)
    );

    always_comb begin
        nxt_res = use_reg ? reg_res : imm_res;
        nxt_c   = use_reg ? reg_c : imm_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            operand   <= '0;
            carry_out <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                operand <= nxt_res;
                if (!ls_mode) carry_out <= nxt_c;
            end
        end
    end

    // R1
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(operand) && $stable(carry_out)));

    // R10
    offset_carry_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ls_mode) |=> $stable(carry_out));

    // R5
    rrx_top_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (ls_mode || !instr[USE_REG]) && kind == SH_ROR
         && imm_amt == '0) |=> operand[W-1] == $past(carry_in));

    // R3
    lsr_full_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (ls_mode || !instr[USE_REG]) && kind == SH_LSR
         && imm_amt == '0) |=> operand == '0);
endmodule

// File: tb/sim_opshift_unit.sv
module sim_opshift_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        ls_mode = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rm_val = '0;
    logic [31:0] pc = '0;
    logic        carry_in = 1'b0;
    logic [31:0] amt_reg = '0;
    logic        out_valid;
    logic [31:0] operand;
    logic        carry_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic        e_vld = 1'b0;
    logic [31:0] e_op = '0;
    logic        e_c = 1'b0;
    string       e_tag = "R11";

    always #2 clk = ~clk;

    opshift_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ls_mode(ls_mode),
        .instr(instr), .rm_val(rm_val), .pc(pc), .carry_in(carry_in),
        .amt_reg(amt_reg), .out_valid(out_valid), .operand(operand),
        .carry_out(carry_out)
    );

    // Behavioural model: one bit per step, amount remapping done up front.
    function automatic void model(input logic [31:0] x, input int typ,
                                  input int amt, input bit is_reg, input bit cin,
                                  output logic [31:0] r, output bit c);
        r = x;
        c = cin;
        if (!is_reg && amt == 0) begin
            if (typ == 1 || typ == 2) amt = 32;
            if (typ == 3) begin
                c = x[0];
                r = {cin, x[31:1]};
                return;
            end
        end
        if (typ == 3) begin
            if (amt == 0) return;
            if (amt % 32 == 0) begin
                c = x[31];
                return;
            end
            amt = amt % 32;
        end
        for (int i = 0; i < amt; i++) begin
            case (typ)
                0: begin c = r[31]; r = r << 1; end
                1: begin c = r[0];  r = r >> 1; end
                2: begin c = r[0];  r = {r[31], r[31:1]}; end
                default: begin c = r[0]; r = {r[0], r[31:1]}; end
            endcase
        end
    endfunction

    task automatic compare();
        n_cmp++;
        if (out_valid !== e_vld || operand !== e_op || carry_out !== e_c) begin
            n_bad++;
            $display("FAIL %s: got vld=%0b op=%08h c=%0b, expected vld=%0b op=%08h c=%0b",
                     e_tag, out_valid, operand, carry_out, e_vld, e_op, e_c);
        end
    endtask

    // Check the previous result, then drive the next input set.
    task automatic step(input bit v, input bit ls, input logic [31:0] ins,
                        input logic [31:0] rmv, input logic [31:0] pcv,
                        input bit cin, input logic [31:0] amr);
        logic [31:0] x, r;
        bit c;
        int typ, amt;
        bit isr;
        @(negedge clk);
        compare();
        in_valid = v; ls_mode = ls; instr = ins; rm_val = rmv;
        pc = pcv; carry_in = cin; amt_reg = amr;
        e_tag = "R11";
        if (v) begin
            x   = (ins[3:0] == 4'hF) ? pcv + 32'd8 : rmv;
            typ = int'(ins[6:5]);
            isr = ins[4] && !ls;
            amt = isr ? int'(amr[7:0]) : int'(ins[11:7]);
            model(x, typ, amt, isr, cin, r, c);
            e_vld = 1'b1;
            e_op  = r;
            if (!ls) e_c = c;
            if (ls) e_tag = "R10";
            else if (ins[3:0] == 4'hF) e_tag = "R6";
            else if (!isr) e_tag = (typ == 0) ? "R2" : (typ == 1) ? "R3" : (typ == 2) ? "R4" : "R5";
            else if (amt == 0 || amt < 32) e_tag = "R7";
            else if (typ < 2) e_tag = "R8";
            else e_tag = "R9";
        end else begin
            e_vld = 1'b0;
        end
    endtask

    function automatic logic [31:0] mk(input int n, input int typ, input bit r,
                                       input int idx);
        logic [31:0] w;
        w = $urandom;
        w[11:7] = 5'(n);
        w[6:5]  = 2'(typ);
        w[4]    = r;
        w[3:0]  = 4'(idx);
        return w;
    endfunction

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 200000) begin
                n_bad++;
                $display("FAIL watchdog: got hung run, expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] a = 32'hC000_0005;
        logic [31:0] b = 32'h4000_0002;
        int amts[8] = '{0, 1, 31, 32, 33, 64, 255, 96};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state checked at the first compare
        for (int t = 0; t < 4; t++) begin
            // R2 R3 R4 R5: immediate zero and nonzero amounts
            step(1, 0, mk(0, t, 0, 2), a, 0, 1, 0);
            step(1, 0, mk(0, t, 0, 2), b, 0, 0, 0);
            step(1, 0, mk(1, t, 0, 2), a, 0, 0, 0);
            step(1, 0, mk(31, t, 0, 2), a, 0, 1, 0);
            step(1, 0, mk(7, t, 0, 2), b, 0, 1, 0);
            // R7 R8 R9: register amounts around the word width
            foreach (amts[k]) begin
                step(1, 0, mk(3, t, 1, 4), a, 0, 1, {24'hABCDEF, 8'(amts[k])});
                step(1, 0, mk(3, t, 1, 4), b, 0, 0, {24'h000100, 8'(amts[k])});
            end
            // R10: offset mode with bit 4 set, carry must hold
            step(1, 0, mk(1, 0, 0, 2), a, 0, 0, 0);
            step(1, 1, mk(0, t, 1, 3), a, 0, 1, 32'd40);
            step(1, 1, mk(4, t, 1, 3), b, 0, 1, 32'd1);
            // R6: source index 15 uses pc+8
            step(1, 0, mk(2, t, 0, 15), a, 32'h7FFF_FFFC, 1, 0);
            // R11: idle cycles hold outputs
            step(0, 0, mk(5, t, 0, 1), b, 0, 1, 0);
            step(0, 1, mk(5, t, 0, 1), a, 0, 0, 0);
        end
        // R1: random mix
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 5) != 0, ($urandom % 4) == 0, $urandom,
                 $urandom, $urandom, 1'($urandom), {$urandom} % 300);
        end
        step(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule